// File: doc/BRIEF.md
# General-Purpose I/O Port Controller with Atomic Set/Clear

This block is a memory-mapped controller for a bank of general-purpose I/O lines. There are 32 lines by default, and the count is a parameter. Software never rewrites the whole output word to change one line. It writes a mask of ones to a set register or a clear register instead, and only the selected bits of the output data register change. Two controls decide how each line reaches its pad. An output-enable bit lets the line drive the pad at all. An open-drain bit makes the line pull low or release, where otherwise it drives both levels. A separately addressed pin status register reports the level actually seen on each pad. This is the real pad level, which is not always the level the controller is trying to drive.

Pad levels pass through a two-stage synchronizer before they reach the pin status register. A port clock enable qualifies the synchronizer. While the enable is low, the pin status register keeps the last levels it captured. Register writes and pad driving carry on as normal during that time.

Each bus cycle presents one address, and the address is decoded into a register-select value. The select values are:

- `SEL_OE_SET`, `SEL_OE_CLR`, `SEL_OE_STAT`: output-enable set, clear and status.
- `SEL_OUT_SET`, `SEL_OUT_CLR`, `SEL_OUT_DATA`: output data set, clear and direct access.
- `SEL_PIN_DATA`: pin status.
- `SEL_OD_EN`: open-drain enable.
- `SEL_NONE`: any unmapped address.

Each register access is a single-cycle operation on the select value of that cycle. There is no sequencing between accesses.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A write to byte address 0x10 sets every output data bit whose write-data bit is 1; bits written as 0 keep their value.
- R2: A write to byte address 0x14 clears every output data bit whose write-data bit is 1; bits written as 0 keep their value.
- R3: Byte address 0x18 reads the output data register and, when written, loads it with the full write data.
- R4: Output enables are set by writing ones to 0x00 and cleared by writing ones to 0x04. Address 0x08 reads them. A line whose enable is 0 never asserts its pad drive enable.
- R5: An enabled line in push-pull mode (open-drain bit 0) asserts pad drive enable and drives its output data bit.
- R6: Byte address 0x20 is the read/write open-drain enable. An enabled open-drain line drives 0 when its output data bit is 0 and releases the pad (drive enable 0) when the bit is 1. In this mode the pin status can differ from the output data.
- R7: Byte address 0x18 + 4 = 0x1C reads the pin status, which is the pad level delayed by two enabled clock edges. Writes to this address change nothing.
- R8: While the port clock enable is low, the pin status holds its value whatever the pads do. Two enabled edges after the enable returns, it reflects the current pads.
- R9: After reset, the output enables, output data, open-drain enables and pin status all read 0.
- R10: Read data is combinational in the cycle the read strobe is high. It is 0 for unmapped addresses and 0 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Port clock enable; qualifies pad sampling |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Read data |
| pad_in | input | NLINES | Level sensed on each pad |
| pad_out | output | NLINES | Level driven on each pad |
| pad_oe | output | NLINES | Drive enable for each pad |

## Verification
The assertions assume the following:

- No more than one of write and read is meaningful per cycle.
- `pad_in` changes only between clock edges, so a two-edge-old sample equals the pin status.
- Open-drain lines that are released are pulled by the board rather than left floating at X.

The bench models the board with a resistor-like rule: each pad follows `pad_out` when `pad_oe` is set and an externally chosen level otherwise. It changes every input only on falling edges, and it sweeps all output-enable masks and set/clear masks of an 8-line configuration.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef logic [7:0] addr_t;

    localparam addr_t OFS_OE_SET   = 8'h00;
    localparam addr_t OFS_OE_CLR   = 8'h04;
    localparam addr_t OFS_OE_STAT  = 8'h08;
    localparam addr_t OFS_OUT_SET  = 8'h10;
    localparam addr_t OFS_OUT_CLR  = 8'h14;
    localparam addr_t OFS_OUT_DATA = 8'h18;
    localparam addr_t OFS_PIN_DATA = 8'h1C;
    localparam addr_t OFS_OD_EN    = 8'h20;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_OE_SET,
        SEL_OE_CLR,
        SEL_OE_STAT,
        SEL_OUT_SET,
        SEL_OUT_CLR,
        SEL_OUT_DATA,
        SEL_PIN_DATA,
        SEL_OD_EN
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input addr_t a);
        reg_sel_e s;
        unique case (a)
            OFS_OE_SET:   s = SEL_OE_SET;
            OFS_OE_CLR:   s = SEL_OE_CLR;
            OFS_OE_STAT:  s = SEL_OE_STAT;
            OFS_OUT_SET:  s = SEL_OUT_SET;
            OFS_OUT_CLR:  s = SEL_OUT_CLR;
            OFS_OUT_DATA: s = SEL_OUT_DATA;
            OFS_PIN_DATA: s = SEL_PIN_DATA;
            OFS_OD_EN:    s = SEL_OD_EN;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_port_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic              wr,
    input  logic [NLINES-1:0] wdata,
    output logic [NLINES-1:0] oe_q,
    output logic [NLINES-1:0] odsr_q,
    output logic [NLINES-1:0] od_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q   <= '0;
            odsr_q <= '0;
            od_q   <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_OE_SET:   oe_q   <= oe_q | wdata;
                SEL_OE_CLR:   oe_q   <= oe_q & ~wdata;
                SEL_OUT_SET:  odsr_q <= odsr_q | wdata;
                SEL_OUT_CLR:  odsr_q <= odsr_q & ~wdata;
                SEL_OUT_DATA: odsr_q <= wdata;
                SEL_OD_EN:    od_q   <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NLINES = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [NLINES-1:0] d,
    output logic [NLINES-1:0] q
);

    logic [NLINES-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else if (en) begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int NLINES = 32
) (
    input  logic [NLINES-1:0] oe,
    input  logic [NLINES-1:0] odsr,
    input  logic [NLINES-1:0] od,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe
);

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        always_comb begin
            if (od[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = oe[i] & ~odsr[i];
            end else begin
                pad_out[i] = odsr[i];
                pad_oe[i]  = oe[i];
            end
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe
);

    reg_sel_e          sel;
    logic [NLINES-1:0] oe_q, odsr_q, od_q, pin_q;

    assign sel = decode_addr(bus_addr);

    gpio_reg_bank #(.NLINES(NLINES)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .oe_q  (oe_q),
        .odsr_q(odsr_q),
        .od_q  (od_q)
    );

    gpio_in_sync #(.NLINES(NLINES), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (clk_en),
        .d    (pad_in),
        .q    (pin_q)
    );

    gpio_pad_drive #(.NLINES(NLINES)) u_drive (
        .oe     (oe_q),
        .odsr   (odsr_q),
        .od     (od_q),
        .pad_out(pad_out),
        .pad_oe (pad_oe)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_OE_STAT:  bus_rdata = oe_q;
                SEL_OUT_DATA: bus_rdata = odsr_q;
                SEL_PIN_DATA: bus_rdata = pin_q;
                SEL_OD_EN:    bus_rdata = od_q;
                default:      bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NLINES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic [7:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [NLINES-1:0] bus_wdata,
    input logic [NLINES-1:0] bus_rdata,
    input logic [NLINES-1:0] pad_in,
    input logic [NLINES-1:0] pad_out,
    input logic [NLINES-1:0] pad_oe,
    input logic [NLINES-1:0] oe_q,
    input logic [NLINES-1:0] odsr_q,
    input logic [NLINES-1:0] od_q,
    input logic [NLINES-1:0] pin_q
);

    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R1
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_OUT_SET) |=> odsr_q == ($past(odsr_q) | $past(bus_wdata)));

    // R2
    out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_OUT_CLR) |=> odsr_q == ($past(odsr_q) & ~$past(bus_wdata)));

    // R4
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~oe_q) == '0);

    // R6
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & od_q & odsr_q) == '0) && ((pad_out & od_q) == '0));

    // R7
    sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && clk_en && $past(clk_en)) |=> pin_q == $past(pad_in, 2));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(pin_q));

    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

endmodule

bind gpio_port_ctrl gpio_port_chk #(.NLINES(NLINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .oe_q     (oe_q),
    .odsr_q   (odsr_q),
    .od_q     (od_q),
    .pin_q    (pin_q)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_en = 1'b1;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pad_in, pad_out, pad_oe;
    logic [N-1:0] ext = '0;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    // board model: driven pads follow the port, released pads follow ext
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_port_ctrl #(.NLINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic summary;
        $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finished");
        summary();
    end

    initial begin
        logic [N-1:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rd_reg(8'h08, r); chk("R9 oe reset", r, '0);
        rd_reg(8'h18, r); chk("R9 odsr reset", r, '0);
        rd_reg(8'h20, r); chk("R9 od reset", r, '0);
        rd_reg(8'h1C, r); chk("R9 pdsr reset", r, '0);
        chk("R9 pad_oe reset", pad_oe, '0);

        // R10 idle and unmapped reads
        @(negedge clk); bus_addr = 8'h18; #1 chk("R10 idle rdata", bus_rdata, '0);
        wr_reg(8'h18, 8'hA5);
        rd_reg(8'h0C, r); chk("R10 unmapped 0x0C", r, '0);
        rd_reg(8'h19, r); chk("R10 unmapped 0x19", r, '0);

        // R3 direct load/readback
        rd_reg(8'h18, r); chk("R3 odsr readback", r, 8'hA5);

        // R1 / R2 sweeps over every mask
        for (int v = 0; v < 256; v++) begin
            wr_reg(8'h18, 8'h3C);
            wr_reg(8'h10, 8'(v));
            rd_reg(8'h18, r); chk("R1 set mask", r, 8'h3C | 8'(v));
            wr_reg(8'h14, 8'(v));
            rd_reg(8'h18, r); chk("R2 clear mask", r, (8'h3C | 8'(v)) & ~8'(v));
        end

        // R4 output enable set/clear/status
        wr_reg(8'h00, 8'h0F);
        wr_reg(8'h00, 8'h30);
        rd_reg(8'h08, r); chk("R4 oe set", r, 8'h3F);
        wr_reg(8'h04, 8'h05);
        rd_reg(8'h08, r); chk("R4 oe clear", r, 8'h3A);
        chk("R4 pad_oe follows oe", pad_oe, 8'h3A);

        // R5 / R6 drive sweep over every enable mask
        wr_reg(8'h20, 8'h55);
        rd_reg(8'h20, r); chk("R6 od readback", r, 8'h55);
        wr_reg(8'h18, 8'h33);
        for (int e = 0; e < 256; e++) begin
            wr_reg(8'h04, 8'hFF);
            wr_reg(8'h00, 8'(e));
            @(negedge clk);
            chk("R5 R6 pad_oe", pad_oe, 8'(e) & ~(8'h55 & 8'h33));
            chk("R5 R6 pad_out", pad_out & pad_oe, 8'(e) & 8'h33 & ~8'h55 & ~(8'h55 & 8'h33));
        end

        // R6 open-drain: released line pulled low externally disagrees with odsr
        wr_reg(8'h00, 8'hFF);
        wr_reg(8'h20, 8'hFF);
        wr_reg(8'h18, 8'hF0);
        ext = 8'h7F;
        repeat (3) @(negedge clk);
        chk("R6 od pad_oe", pad_oe, 8'h0F);
        rd_reg(8'h1C, r); chk("R6 pdsr vs odsr", r, 8'h70);
        rd_reg(8'h18, r); chk("R6 odsr kept", r, 8'hF0);

        // R7 latency: all lines released so pads follow ext
        wr_reg(8'h04, 8'hFF);
        ext = 8'h11;
        repeat (3) @(negedge clk);
        @(negedge clk); ext = 8'hC6; bus_addr = 8'h1C; bus_rd = 1'b1;
        #1 chk("R7 before edge", bus_rdata, 8'h11);
        @(negedge clk); #1 chk("R7 after one edge", bus_rdata, 8'h11);
        @(negedge clk); #1 chk("R7 after two edges", bus_rdata, 8'hC6);
        bus_rd = 1'b0;

        // R7 read-only
        wr_reg(8'h1C, 8'h00);
        rd_reg(8'h1C, r); chk("R7 write ignored pdsr", r, 8'hC6);
        rd_reg(8'h18, r); chk("R7 write ignored odsr", r, 8'hF0);

        // R8 freeze
        @(negedge clk); clk_en = 1'b0; ext = 8'h3B;
        repeat (6) @(negedge clk);
        rd_reg(8'h1C, r); chk("R8 frozen", r, 8'hC6);
        wr_reg(8'h10, 8'h01);
        rd_reg(8'h18, r); chk("R8 writes still work", r, 8'hF1);
        @(negedge clk); clk_en = 1'b1; bus_addr = 8'h1C; bus_rd = 1'b1;
        @(negedge clk); #1 chk("R8 one edge after enable", bus_rdata, 8'hC6);
        @(negedge clk); #1 chk("R8 two edges after enable", bus_rdata, 8'h3B);
        bus_rd = 1'b0;

        summary();
    end

endmodule